// File: doc/BRIEF.md
# I2C Bus Recovery Controller

This block sits beside an I2C master and restores a bus left hung by a target. While the master reports that it is not transferring, the block watches both bus lines. If SCL stays low for a programmed number of system clocks, no target can be clocked free. The block therefore reports an SCL-stuck error and never drives the bus. If SDA stays low while SCL is high for the same number of clocks, a target is assumed to be stranded mid-byte. The block then pulls SCL low and releases it, one pulse at a time, to clock the target through the rest of its byte.

SDA is sampled at the end of the high half of every pulse, and pulsing stops at the first high sample. The block then generates a STOP condition and reports success. A target left in the middle of a write therefore sees a STOP and cannot take random data into a register. If SDA is still low after nine pulses, the block gives up and reports a failure. Every final status holds until the host clears it.

Top module: `bus_unhang_ctrl`

## Requirements
- R1: After reset, `status` is 0 (idle) and neither `scl_pull` nor `sda_pull` is asserted. The status codes are: 0 idle, 1 recovering, 2 recovered, 3 SCL stuck, 4 SDA stuck failure.
- R2: While the status is idle and `host_idle` is 1, SCL low for `stuck_limit` consecutive clocks makes the status 3. With status 3, neither line is ever pulled.
- R3: While the status is idle and `host_idle` is 1, SDA low with SCL high for `stuck_limit` consecutive clocks makes the status 1 at that clock edge, and `scl_pull` is asserted from the same edge.
- R4: Each recovery pulse pulls SCL low for `half_period` clocks and then releases it for `half_period` clocks.
- R5: SDA is sampled on the last clock of each released half. The first high sample ends pulsing, so a target that frees SDA after N falling SCL edges sees exactly N pulses.
- R6: At most 9 pulses are issued. If SDA is still low after the ninth pulse, the status becomes 4 and both lines are released.
- R7: Once SDA is free, a STOP is generated in three phases of `half_period` clocks each: SCL and SDA both pulled, then only SDA pulled, then both released. The status becomes 2 at the end of the third phase.
- R8: Statuses 2, 3 and 4 hold until `clr_status` is 1 at a clock edge, which returns the status to 0.
- R9: While `host_idle` is 0 no stuck condition is counted. A low level shorter than `stuck_limit` clocks restarts the count and triggers nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idle | input | 1 | 1 while the master is not transferring, so the bus should be free |
| clr_status | input | 1 | Returns a final status to idle |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| stuck_limit | input | TO_W | Stuck timeout in clocks (at least 1) |
| half_period | input | HP_W | Half of the recovery bit period in clocks (at least 1) |
| scl_pull | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| status | output | 3 | Recovery status code |

## Verification
The hardest cases to reach are the two ends of the pulse budget: a target that lets go of SDA exactly on the ninth pulse, and a target that never lets go. Both must be told apart from the ports. The bench therefore models the target as a counter of falling SCL edges on the shared open-drain line. The target releases SDA after a programmed number of edges, and a large count means it never releases. The bench then runs releases after 1, 3 and 9 edges as well as the permanent hold, and compares pulse count, pulse width and final status against a behavioural model on every clock.

// File: rtl/bus_unhang_pkg.sv
package bus_unhang_pkg;

  typedef enum logic [2:0] {
    STAT_IDLE      = 3'd0,
    STAT_RECOVERING = 3'd1,
    STAT_RECOVERED = 3'd2,
    STAT_SCL_STUCK = 3'd3,
    STAT_SDA_FAIL  = 3'd4
  } status_e;

  typedef enum logic [3:0] {
    FS_IDLE,
    FS_PULSE_LO,
    FS_PULSE_HI,
    FS_STOP_A,
    FS_STOP_B,
    FS_STOP_C,
    FS_DONE,
    FS_SCL_ERR,
    FS_SDA_ERR
  } fsm_e;

  function automatic status_e fsm_status(input fsm_e st);
    case (st)
      FS_IDLE:    fsm_status = STAT_IDLE;
      FS_DONE:    fsm_status = STAT_RECOVERED;
      FS_SCL_ERR: fsm_status = STAT_SCL_STUCK;
      FS_SDA_ERR: fsm_status = STAT_SDA_FAIL;
      default:    fsm_status = STAT_RECOVERING;
    endcase
  endfunction

endpackage

// File: rtl/stuck_timer.sv
module stuck_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [TO_W-1:0] limit,
  output logic            hit
);

  logic [TO_W-1:0] cnt_q, cnt_d;

  assign hit = arm && (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || hit) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int HP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] len,
  output logic            done
);

  logic [HP_W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == len - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bus_unhang_ctrl.sv
module bus_unhang_ctrl
  import bus_unhang_pkg::*;
#(
  parameter int TO_W       = 16,
  parameter int HP_W       = 12,
  parameter int MAX_PULSES = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_idle,
  input  logic            clr_status,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [TO_W-1:0] stuck_limit,
  input  logic [HP_W-1:0] half_period,
  output logic            scl_pull,
  output logic            sda_pull,
  output logic [2:0]      status
);

  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(MAX_PULSES - 1);
  localparam int N_WATCH = 2;

  fsm_e            state_q, state_d;
  logic [PC_W-1:0] pulses_q, pulses_d;
  logic            scl_pull_q, sda_pull_q;
  logic [N_WATCH-1:0] watch_arm, watch_hit;
  logic            ph_run, ph_done;

  // index 0: SCL low, index 1: SDA low with SCL high
  assign watch_arm[0] = (state_q == FS_IDLE) && host_idle && !scl_in;
  assign watch_arm[1] = (state_q == FS_IDLE) && host_idle && scl_in && !sda_in;

  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    stuck_timer #(.TO_W(TO_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (watch_arm[g]),
      .limit (stuck_limit),
      .hit   (watch_hit[g])
    );
  end

  assign ph_run = (state_q == FS_PULSE_LO) || (state_q == FS_PULSE_HI) ||
                  (state_q == FS_STOP_A)   || (state_q == FS_STOP_B)   ||
                  (state_q == FS_STOP_C);

  phase_timer #(.HP_W(HP_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ph_run),
    .len   (half_period),
    .done  (ph_done)
  );

  always_comb begin
    state_d  = state_q;
    pulses_d = pulses_q;
    case (state_q)
      FS_IDLE: begin
        pulses_d = '0;
        if (watch_hit[0])      state_d = FS_SCL_ERR;
        else if (watch_hit[1]) state_d = FS_PULSE_LO;
      end
      FS_PULSE_LO: if (ph_done) state_d = FS_PULSE_HI;
      FS_PULSE_HI: begin
        if (ph_done) begin
          pulses_d = pulses_q + 1'b1;
          if (sda_in)                     state_d = FS_STOP_A;
          else if (pulses_q == LAST_PULSE) state_d = FS_SDA_ERR;
          else                            state_d = FS_PULSE_LO;
        end
      end
      FS_STOP_A: if (ph_done) state_d = FS_STOP_B;
      FS_STOP_B: if (ph_done) state_d = FS_STOP_C;
      FS_STOP_C: if (ph_done) state_d = FS_DONE;
      FS_DONE, FS_SCL_ERR, FS_SDA_ERR: if (clr_status) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      pulses_q   <= '0;
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pulses_q   <= pulses_d;
      scl_pull_q <= (state_d == FS_PULSE_LO) || (state_d == FS_STOP_A);
      sda_pull_q <= (state_d == FS_STOP_A) || (state_d == FS_STOP_B);
    end
  end

  assign scl_pull = scl_pull_q;
  assign sda_pull = sda_pull_q;
  assign status   = fsm_status(state_q);

endmodule

// File: rtl/bus_unhang_chk.sv
module bus_unhang_chk
  import bus_unhang_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_status,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [2:0] status
);

  localparam int CW = $clog2(MAX_PULSES + 2) + 1;

  logic          scl_prev;
  logic [CW-1:0] seen_pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev    <= 1'b0;
      seen_pulses <= '0;
    end else begin
      scl_prev <= scl_pull;
      if (status == 3'(STAT_IDLE))
        seen_pulses <= '0;
      else if (scl_pull && !scl_prev && !sda_pull && seen_pulses != '1)
        seen_pulses <= seen_pulses + 1'b1;
    end
  end

  a_r2_scl_stuck_hands_off: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'(STAT_SCL_STUCK)) |-> (!scl_pull && !sda_pull));

  a_r6_pulse_budget: assert property (@(posedge clk) disable iff (!rst_n)
    seen_pulses <= CW'(MAX_PULSES));

  a_r6_fail_released: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'(STAT_SDA_FAIL)) |-> (!scl_pull && !sda_pull));

  a_r7_stop_sda_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);

  a_r7_sda_only_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (status == 3'(STAT_RECOVERING)));

  a_r8_final_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status >= 3'(STAT_RECOVERED) && !clr_status) |=> (status == $past(status)));

endmodule

bind bus_unhang_ctrl bus_unhang_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_status (clr_status),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .status     (status)
);

// File: tb/bus_unhang_ctrl_bench.sv
`timescale 1ns/1ps
module bus_unhang_ctrl_bench;

  localparam int TO = 20;
  localparam int HP = 4;
  localparam int BUDGET = 9;
  localparam int FOREVER_N = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_idle = 1'b0;
  logic clr_status = 1'b0;
  logic scl_pull, sda_pull;
  logic [2:0] status;

  logic tgt_en = 1'b0;
  logic tgt_rst = 1'b0;
  logic tgt_scl_low = 1'b0;
  int   tgt_n = 0;
  int   tgt_falls = 0;
  wire  tgt_sda_low = tgt_en && (tgt_n >= FOREVER_N || tgt_falls < tgt_n);
  wire  scl_line = ~(scl_pull | tgt_scl_low);
  wire  sda_line = ~(sda_pull | tgt_sda_low);

  always #10 clk = ~clk;

  bus_unhang_ctrl u_bus_unhang_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_idle   (host_idle),
    .clr_status  (clr_status),
    .scl_in      (scl_line),
    .sda_in      (sda_line),
    .stuck_limit (16'(TO)),
    .half_period (12'(HP)),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .status      (status)
  );

  // target: holds SDA until it has seen tgt_n falling SCL edges
  always @(negedge scl_line or posedge tgt_rst)
    if (tgt_rst) tgt_falls <= 0;
    else         tgt_falls <= tgt_falls + 1;

  // behavioural reference
  int m_mode, m_ph, m_tmr, m_np, m_cs, m_cd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_tmr = 0; m_np = 0; m_cs = 0; m_cd = 0;
    end else begin
      case (m_mode)
        0: begin
          m_cs = (host_idle && !scl_line) ? m_cs + 1 : 0;
          m_cd = (host_idle && scl_line && !sda_line) ? m_cd + 1 : 0;
          if (m_cs == TO) begin
            m_mode = 3; m_cs = 0; m_cd = 0;
          end else if (m_cd == TO) begin
            m_mode = 1; m_ph = 0; m_tmr = 0; m_np = 0; m_cs = 0; m_cd = 0;
          end
        end
        1: begin
          m_tmr = m_tmr + 1;
          if (m_tmr == HP) begin
            m_tmr = 0;
            if (m_ph == 1) begin
              m_np = m_np + 1;
              if (sda_line)           m_ph = 2;
              else if (m_np == BUDGET) m_mode = 4;
              else                     m_ph = 0;
            end else if (m_ph == 4) m_mode = 2;
            else if (m_ph == 0)     m_ph = 1;
            else                    m_ph = m_ph + 1;
          end
        end
        default: if (clr_status) m_mode = 0;
      endcase
    end
  end

  string cur_req = "R1";
  int cyc_vec = 0, cyc_bad = 0;
  int obs_pulses = 0, run_len = 0, last_w = 0;
  logic prev_scl = 1'b0;

  always @(negedge clk) begin
    automatic bit e_scl = (m_mode == 1) && (m_ph == 0 || m_ph == 2);
    automatic bit e_sda = (m_mode == 1) && (m_ph == 2 || m_ph == 3);
    cyc_vec++;
    if (status !== 3'(m_mode) || scl_pull !== e_scl || sda_pull !== e_sda) begin
      cyc_bad++;
      $display("FAIL %s per-cycle: status/scl/sda = %0d/%0b/%0b expected %0d/%0b/%0b",
               cur_req, status, scl_pull, sda_pull, m_mode, e_scl, e_sda);
    end
    if (scl_pull && !prev_scl && !sda_pull) obs_pulses++;
    if (scl_pull && !sda_pull) run_len++;
    else begin
      if (run_len > 0) last_w = run_len;
      run_len = 0;
    end
    prev_scl = scl_pull;
  end

  int n_vec = 0, n_bad = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_final();
    for (int i = 0; i < 3000; i++) begin
      if (status >= 3'd2) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_all();
    tgt_en = 1'b0; tgt_scl_low = 1'b0; tgt_rst = 1'b1; clr_status = 1'b1;
    cycles(1);
    tgt_rst = 1'b0; clr_status = 1'b0;
    cycles(2);
  endtask

  task automatic sda_case(input int n, input int exp_pulses, input int exp_stat,
                          input string req);
    automatic int base;
    cur_req = req;
    tgt_n = n; tgt_rst = 1'b1;
    cycles(1);
    tgt_rst = 1'b0;
    base = obs_pulses;
    tgt_en = 1'b1;
    cycles(TO - 1);
    chk("R3 not yet recovering one clock early", status, 0);
    cycles(1);
    chk("R3 recovering after stuck_limit clocks", status, 1);
    chk("R3 scl pulled at detection", scl_pull, 1);
    wait_final();
    cycles(1);
    chk({req, " final status"}, status, exp_stat);
    chk({req, " pulse count"}, obs_pulses - base, exp_pulses);
    chk("R4 low half width", last_w, HP);
    chk("R6 lines released at end", {30'd0, scl_pull, sda_pull}, 0);
  endtask

  initial begin
    cycles(3);
    chk("R1 reset status", status, 0);
    chk("R1 reset drives", {30'd0, scl_pull, sda_pull}, 0);
    rst_n = 1'b1;
    cycles(2);

    cur_req = "R9";
    tgt_n = FOREVER_N; tgt_en = 1'b1; host_idle = 1'b0;
    cycles(3 * TO);
    chk("R9 no detection while host busy", status, 0);
    tgt_en = 1'b0;
    host_idle = 1'b1;
    cycles(2);
    tgt_en = 1'b1;
    cycles(TO - 1);
    tgt_en = 1'b0;
    cycles(3);
    tgt_en = 1'b1;
    cycles(TO - 1);
    tgt_en = 1'b0;
    cycles(3);
    chk("R9 short lows restart the count", status, 0);
    chk("R9 no pulses", obs_pulses, 0);

    sda_case(3, 3, 2, "R5");
    cur_req = "R8";
    cycles(25);
    chk("R8 recovered holds without clear", status, 2);
    clear_all();
    chk("R8 clear returns to idle", status, 0);

    sda_case(1, 1, 2, "R7");
    clear_all();
    sda_case(9, 9, 2, "R6");
    clear_all();
    sda_case(FOREVER_N, 9, 4, "R6");
    cur_req = "R8";
    cycles(10);
    chk("R8 failure holds", status, 4);
    clear_all();
    chk("R8 failure cleared", status, 0);

    cur_req = "R2";
    begin
      automatic int base = obs_pulses;
      tgt_scl_low = 1'b1;
      cycles(TO - 1);
      chk("R2 not stuck one clock early", status, 0);
      cycles(1);
      chk("R2 scl stuck reported", status, 3);
      cycles(30);
      chk("R2 scl stuck holds", status, 3);
      chk("R2 never pulses", obs_pulses - base, 0);
      chk("R2 no drives", {30'd0, scl_pull, sda_pull}, 0);
    end
    clear_all();
    chk("R8 scl stuck cleared", status, 0);
    cycles(2 * TO);
    chk("R1 stays idle on free bus", status, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec + cyc_vec, n_bad + cyc_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog expired: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + cyc_vec + 1, n_bad + cyc_bad + 1);
    $finish;
  end

endmodule